// File: doc/BRIEF.md
# Page Write Buffer and Self-Timed Commit Engine

This block sits behind a serial memory command decoder. It gathers the data bytes of one array write command into a page-sized staging buffer. When the command's frame closes cleanly, it copies the gathered bytes into the storage array and then holds a busy indication for a fixed programming interval. The decoder marks the frame boundaries with strobes. A protection unit answers, for each array address the block presents, whether that byte may be changed.

The address given at the frame start splits into two parts. The upper bits choose a page, and the low bits (four bits for a 16-byte page) choose the first byte. Each later byte goes to the next offset. After offset 15 the offset wraps back to offset 0 of the same page, so when a frame overruns the page, the most recent bytes win. A per-byte loaded flag records which offsets received data, so a partial page changes only those bytes.

The controller has four states. PG_IDLE waits for a frame start. PG_LOAD stores the arriving bytes. PG_COMMIT walks the offsets 0 to 15, one per clock. PG_WAIT runs the programming timer. The transitions are:
- start (PG_IDLE to PG_LOAD on `frm_start`).
- close (PG_LOAD to PG_COMMIT on `frm_end` with `frm_ok` high and at least one byte held).
- abort (PG_LOAD to PG_IDLE on `frm_end` otherwise).
- sweep-done (PG_COMMIT to PG_WAIT after offset 15).
- expire (PG_WAIT to PG_IDLE when the timer reaches zero).

Top module: `pgwr_engine`

## Requirements
- R1: While reset is held and right after it, `busy`, `mem_we` and `wel_clear` are low.
- R2: A frame start latches the page from `frm_addr[ADDR_W-1:4]` and the first offset from `frm_addr[3:0]`. Each accepted byte lands at the current offset, and the offset then advances by one.
- R3: A byte stored at offset 15 is followed by a byte at offset 0 of the same page. No other page is ever touched by the frame.
- R4: When more than 16 bytes arrive in one frame, each offset keeps the last byte delivered to it. The page therefore ends up holding the final 16 bytes.
- R5: Only offsets that received a byte in the frame are written. Every other byte of the page keeps its prior value.
- R6: A frame that ends with `frm_ok` low, or that carried no byte, leaves the array unchanged and never raises `busy`.
- R7: The commit presents the offsets 0 to 15 in ascending order, one per clock. `mem_we` rises only for loaded offsets.
- R8: A loaded byte is skipped when `wr_permit` is low for the address shown on `mem_addr` in that cycle.
- R9: After a valid close, `busy` is high from the next clock for exactly 16 + `CYCLE_CLKS` cycles.
- R10: `wel_clear` is a single-cycle pulse in the last cycle in which `busy` is high.
- R11: Frame start, byte and frame end strobes that arrive while `busy` is high are ignored. No extra commit follows, and no page changes because of them.
- R12: A byte strobe in the same cycle as a valid `frm_end` is kept and committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_start | input | 1 | Start of a write frame; `frm_addr` is valid |
| frm_addr | input | ADDR_W | First byte address of the frame |
| byte_stb | input | 1 | One data byte is valid on `byte_data` |
| byte_data | input | DATA_W | Data byte |
| frm_end | input | 1 | Frame closed (select released) |
| frm_ok | input | 1 | Frame closed on a whole-byte boundary |
| wr_permit | input | 1 | Protection answer for the current `mem_addr` |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Commit or programming interval in progress |
| wel_clear | output | 1 | Pulse that clears the write-enable latch |

## Verification
Two events can coincide. The last data byte can arrive in the same clock as the frame close, and new decoder strobes can arrive while the busy interval is still running. The bench provokes the first by driving `byte_stb` and `frm_end` together on some frames. It then checks that the final byte appears in the committed page at its wrapped offset. For the second, it sends a full frame aimed at the neighbouring page in the middle of the busy interval. It then checks that busy ends on schedule with a single `wel_clear` pulse, that no second busy period follows, and that the neighbouring page is unchanged.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [1:0] {
        PG_IDLE   = 2'd0,
        PG_LOAD   = 2'd1,
        PG_COMMIT = 2'd2,
        PG_WAIT   = 2'd3
    } pg_state_t;

endpackage

// File: rtl/pgwr_buffer.sv
module pgwr_buffer #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_loaded,
    output logic              any_loaded
);

    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] flag_q;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_off == OFF_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
                flag_q[g] <= 1'b0;
            end else if (hit) begin
                slot_q[g] <= wr_data;
                flag_q[g] <= 1'b1;
            end else if (clr) begin
                flag_q[g] <= 1'b0;
            end
        end
    end

    assign rd_data    = slot_q[rd_off];
    assign rd_loaded  = flag_q[rd_off];
    assign any_loaded = |flag_q;

    // R5: a stored byte is always flagged on the following cycle
    assert_flag_after_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (flag_q[$past(wr_off)] == 1'b1));

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
    parameter int CYCLE_CLKS = 500000,
    localparam int CNT_W     = $clog2(CYCLE_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(CYCLE_CLKS - 1);
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = run && (cnt_q == '0);

    // R9: the count never leaves its programmed range
    assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CYCLE_CLKS - 1));

    // R9: while running and not finished, the count steps down by one
    assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine
    import pgwr_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int CYCLE_CLKS = 500000,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start,
    input  logic [ADDR_W-1:0] frm_addr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              frm_end,
    input  logic              frm_ok,
    input  logic              wr_permit,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              wel_clear
);

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

    pg_state_t         state_q, state_d;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  ptr_q;
    logic [OFF_W-1:0]  scan_q;

    logic              buf_clr, buf_wr;
    logic [DATA_W-1:0] buf_rd_data;
    logic              buf_rd_loaded, buf_any;
    logic              tmr_start, tmr_run, tmr_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PG_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PG_IDLE:   if (frm_start) state_d = PG_LOAD;
            PG_LOAD: begin
                if (frm_end) begin
                    if (frm_ok && (buf_any || byte_stb)) state_d = PG_COMMIT;
                    else                                 state_d = PG_IDLE;
                end
            end
            PG_COMMIT: if (scan_q == LAST_OFF) state_d = PG_WAIT;
            PG_WAIT:   if (tmr_done) state_d = PG_IDLE;
            default:   state_d = PG_IDLE;
        endcase
    end

    // address and offset registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ptr_q  <= '0;
            scan_q <= '0;
        end else begin
            if (state_q == PG_IDLE && frm_start) begin
                page_q <= frm_addr[ADDR_W-1:OFF_W];
                ptr_q  <= frm_addr[OFF_W-1:0];
            end else if (state_q == PG_LOAD && byte_stb) begin
                ptr_q  <= ptr_q + 1'b1;
            end
            if (state_q == PG_COMMIT) scan_q <= scan_q + 1'b1;
            else                      scan_q <= '0;
        end
    end

    assign buf_clr   = (state_q == PG_IDLE) && frm_start;
    assign buf_wr    = (state_q == PG_LOAD) && byte_stb;
    assign tmr_start = (state_q == PG_COMMIT) && (scan_q == LAST_OFF);
    assign tmr_run   = (state_q == PG_WAIT);

    pgwr_buffer #(
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (buf_clr),
        .wr_en      (buf_wr),
        .wr_off     (ptr_q),
        .wr_data    (byte_data),
        .rd_off     (scan_q),
        .rd_data    (buf_rd_data),
        .rd_loaded  (buf_rd_loaded),
        .any_loaded (buf_any)
    );

    pgwr_timer #(
        .CYCLE_CLKS (CYCLE_CLKS)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .run   (tmr_run),
        .done  (tmr_done)
    );

    // outputs
    always_comb begin
        busy      = 1'b0;
        mem_we    = 1'b0;
        wel_clear = 1'b0;
        mem_addr  = {page_q, scan_q};
        mem_wdata = buf_rd_data;
        unique case (state_q)
            PG_IDLE, PG_LOAD: ;
            PG_COMMIT: begin
                busy   = 1'b1;
                mem_we = buf_rd_loaded && wr_permit;
            end
            PG_WAIT: begin
                busy      = 1'b1;
                wel_clear = tmr_done;
            end
            default: ;
        endcase
    end

    // R7: array writes only happen inside the busy interval
    assert_we_inside_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R7: consecutive commit cycles step the offset by one
    assert_scan_ascend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_COMMIT && $past(state_q == PG_COMMIT)) |->
        (scan_q == $past(scan_q) + 1'b1));

    // R2: the page stays fixed across the busy interval
    assert_page_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(page_q));

    // R10: the latch-clear pulse is the final busy cycle
    assert_wel_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clear |=> !busy);

    // R9: busy only falls right after the latch-clear pulse
    assert_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wel_clear));

    // R11: no new frame can begin straight out of a busy cycle
    assert_no_load_from_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (state_q != PG_LOAD));

endmodule

// File: tb/sim_pgwr_engine.sv
`timescale 1ns/1ps
module sim_pgwr_engine;

    localparam int AW  = 10;
    localparam int CYC = 20;
    localparam int BUSY_LEN = 16 + CYC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_start = 1'b0;
    logic [AW-1:0] frm_addr = '0;
    logic byte_stb = 1'b0;
    logic [7:0] byte_data = '0;
    logic frm_end = 1'b0;
    logic frm_ok = 1'b0;
    logic wr_permit;
    logic mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic busy;
    logic wel_clear;
    logic prot_en = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int ord_bad = 0;
    int prev_off = -1;

    logic [7:0] bmem [1024];
    logic [7:0] emem [1024];

    always #5 clk = ~clk;

    assign wr_permit = !(prot_en && mem_addr[0]);

    pgwr_engine #(
        .ADDR_W (AW), .DATA_W (8), .PAGE_BYTES (16), .CYCLE_CLKS (CYC)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .frm_start (frm_start), .frm_addr (frm_addr),
        .byte_stb (byte_stb), .byte_data (byte_data), .frm_end (frm_end),
        .frm_ok (frm_ok), .wr_permit (wr_permit), .mem_we (mem_we),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata), .busy (busy),
        .wel_clear (wel_clear)
    );

    initial begin
        for (int i = 0; i < 1024; i++) begin
            bmem[i] = 8'(i * 3) ^ 8'h5A;
            emem[i] = 8'(i * 3) ^ 8'h5A;
        end
    end

    always @(posedge clk) if (mem_we) bmem[mem_addr] <= mem_wdata;

    // R7: written offsets must rise within one busy interval
    always @(negedge clk) begin
        if (!busy) prev_off = -1;
        else if (mem_we) begin
            if (int'(mem_addr[3:0]) <= prev_off) ord_bad++;
            prev_off = int'(mem_addr[3:0]);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dat(input int seed, input int i);
        return 8'(seed * 37 + i * 11 + 1);
    endfunction

    task automatic cmp_page(input int pg, input string tag);
        int bad = 0, fa = 0, fe = 0;
        for (int o = 0; o < 16; o++) begin
            if (bmem[pg*16+o] !== emem[pg*16+o]) begin
                if (bad == 0) begin
                    fa = int'(bmem[pg*16+o]);
                    fe = int'(emem[pg*16+o]);
                end
                bad++;
            end
        end
        check(bad == 0, tag, fa, fe);
    endtask

    task automatic run_frame(input int pg, input int st, input int len, input bit ok,
                             input bit merge, input bit intrude, input int seed,
                             input string tag);
        logic [7:0] tmp [16];
        bit ld [16];
        bit commit;
        int busy_n, wel_at, other;
        commit = ok && (len > 0);
        other = (pg + 1) % 64;
        for (int o = 0; o < 16; o++) ld[o] = 1'b0;
        for (int i = 0; i < len; i++) begin
            tmp[(st + i) % 16] = dat(seed, i);
            ld[(st + i) % 16] = 1'b1;
        end
        if (commit)
            for (int o = 0; o < 16; o++)
                if (ld[o] && !(prot_en && (o % 2 == 1))) emem[pg*16+o] = tmp[o];

        @(negedge clk);
        frm_start = 1'b1;
        frm_addr = AW'(pg * 16 + st);
        @(negedge clk);
        frm_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            byte_stb = 1'b1;
            byte_data = dat(seed, i);
            if (merge && i == len - 1) begin
                frm_end = 1'b1;
                frm_ok = ok;
            end
            @(negedge clk);
            byte_stb = 1'b0;
        end
        if (!(merge && len > 0)) begin
            frm_end = 1'b1;
            frm_ok = ok;
            @(negedge clk);
        end
        frm_end = 1'b0;
        frm_ok = 1'b0;

        busy_n = 0;
        wel_at = -1;
        for (int k = 0; k < BUSY_LEN + 12; k++) begin
            if (busy) busy_n++;
            if (wel_clear) wel_at = busy_n;
            if (intrude) begin
                if (k == 3) begin frm_start = 1'b1; frm_addr = AW'(other * 16 + 2); end
                if (k == 4) begin frm_start = 1'b0; byte_stb = 1'b1; byte_data = 8'hC3; end
                if (k == 5) begin byte_stb = 1'b0; frm_end = 1'b1; frm_ok = 1'b1; end
                if (k == 6) begin frm_end = 1'b0; frm_ok = 1'b0; end
            end
            @(negedge clk);
        end
        check(busy_n == (commit ? BUSY_LEN : 0), commit ? "R9 busy length" : "R6 no busy",
              busy_n, commit ? BUSY_LEN : 0);
        check(wel_at == (commit ? BUSY_LEN : -1), "R10 wel_clear position",
              wel_at, commit ? BUSY_LEN : -1);
        cmp_page(pg, tag);
        if (intrude) cmp_page(other, "R11 neighbour page untouched");
    endtask

    initial begin
        int seed = 1;
        int lens [5] = '{1, 4, 16, 19, 33};
        repeat (3) @(negedge clk);
        check(!busy && !mem_we && !wel_clear, "R1 in reset", int'({busy, mem_we, wel_clear}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mem_we && !wel_clear, "R1 after reset", int'({busy, mem_we, wel_clear}), 0);

        for (int p = 0; p < 2; p++) begin
            prot_en = (p == 1);
            for (int st = 0; st < 16; st++) begin
                for (int li = 0; li < 5; li++) begin
                    string tag;
                    int len = lens[li];
                    if (prot_en)             tag = "R8 permit skip";
                    else if (len > 16)       tag = "R4 last sixteen kept";
                    else if (li == 1)        tag = "R12 byte with close";
                    else if (st + len > 16)  tag = "R3 wrap in page";
                    else if (len < 16)       tag = "R5 partial page";
                    else                     tag = "R2 full page";
                    run_frame((st * 3 + li * 7 + p * 29) % 64, st, len, 1'b1,
                              li == 1, 1'b0, seed, tag);
                    seed++;
                end
            end
        end
        prot_en = 1'b0;
        run_frame(12, 5, 7, 1'b0, 1'b0, 1'b0, seed++, "R6 broken frame");
        run_frame(13, 9, 0, 1'b1, 1'b0, 1'b0, seed++, "R6 empty frame");
        run_frame(40, 14, 5, 1'b1, 1'b0, 1'b1, seed++, "R11 busy frame");
        check(ord_bad == 0, "R7 ascending commit", ord_bad, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule